// File: doc/BRIEF.md
# TFT Panel Raster Timing Generator

This block produces the raster timing for a TFT panel: a pixel clock enable derived from the bus clock, the horizontal and vertical sync pulses, a data-enable strobe, and the column and row of the pixel being shown. All timing comes from register-style inputs. These are the clock divider, the sync width, back porch and front porch for each axis, the active pixel count, the active line count, and one polarity-invert bit per sync. Every count input holds its value minus one.

A line is a run of pixel positions in this order: sync, back porch, active, front porch. A frame is a run of lines in the same order. A run input starts and stops frame generation. While run is low, all counters are held at the first position of the first vsync line and the outputs are held idle. Downstream logic samples its pixel data on data-enable and uses the column and row to address it.

Top module: `tft_timing_gen`

## Requirements
- R1: `pix_ce` is high for exactly one bus clock cycle in every 2*(`clk_div`+1) cycles. `clk_div` is 10 bits wide, and 0 gives a period of 2. The first pulse comes 2*(`clk_div`+1) cycles after the first cycle of generation.
- R2: Every pixel position lasts one `pix_ce` period. A line holds (`h_sw`+1)+(`h_bp`+1)+(`h_act`+1)+(`h_fp`+1) positions, in the order sync, back porch, active, front porch. A new position begins in the cycle after a `pix_ce` pulse.
- R3: Horizontal sync is active for the first `h_sw`+1 positions of every line.
- R4: A frame holds (`v_sw`+1)+(`v_bp`+1)+(`v_act`+1)+(`v_fp`+1) lines. Vertical sync is active for all positions of the first `v_sw`+1 lines.
- R5: `de` is high exactly when the position is one of the `h_act`+1 positions that follow the horizontal back porch and the line is one of the `v_act`+1 lines that follow the vertical back porch. `de` is never high while either sync is active.
- R6: While `de` is high, `col` and `row` give the pixel index, counted from 0 at the first active position and line. `col` never exceeds `h_act`. Both outputs are 0 while `de` is low.
- R7: With an invert bit at 0, the matching sync output is high when active and low when inactive. With the bit at 1, both levels are swapped, so active is low.
- R8: While generation runs, `hsync`, `vsync` (apart from a change of invert bit), `de`, `col` and `row` hold their values in every cycle that does not follow a `pix_ce` pulse.
- R9: One cycle after `run` is sampled low, both syncs show their inactive level, and `de`, `pix_ce`, `col` and `row` are 0. One cycle after `run` is sampled high, the frame restarts at the first position of the first vsync line.
- R10: During and after reset, before `run` is sampled high, the outputs are in the idle state described in R9.
- R11: A value of 0 in any porch or sync-width field gives a width of one unit. A frame with every field at 0 is 4 positions by 4 lines.

Detailed check coverage by requirement is in the Verification section; port definitions follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Frame generation enable |
| clk_div | input | DIV_W (10) | Pixel clock divider; period is 2*(value+1) |
| h_sw | input | PW (8) | Horizontal sync width minus one, in pixels |
| h_bp | input | PW (8) | Horizontal back porch minus one, in pixels |
| h_act | input | HW (11) | Active pixels per line minus one |
| h_fp | input | PW (8) | Horizontal front porch minus one, in pixels |
| v_sw | input | PW (8) | Vertical sync width minus one, in lines |
| v_bp | input | PW (8) | Vertical back porch minus one, in lines |
| v_act | input | VW (11) | Active lines per frame minus one |
| v_fp | input | PW (8) | Vertical front porch minus one, in lines |
| hs_inv | input | 1 | Set for an active-low horizontal sync |
| vs_inv | input | 1 | Set for an active-low vertical sync |
| pix_ce | output | 1 | Pixel clock enable, one bus cycle wide |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| col | output | HW (11) | Active pixel column |
| row | output | VW (11) | Active line number |

## Verification
Sampling `run` high takes one bus clock edge. The first pixel position then appears in the cycle after that edge. After that, each position lasts 2*(`clk_div`+1) cycles, and `pix_ce` is high in the last cycle of each position. The syncs, `de`, `col` and `row` move one cycle after each pulse, and the idle state appears one cycle after `run` is sampled low. The bench samples every falling edge, counts the rising edges since it raised `run`, and derives the expected position, line and pulse from that count and the programmed fields. Each cycle of every scenario is therefore compared against the exact cycle in which each output is due.

// File: rtl/tft_timing_gen.sv
module tft_timing_gen #(
  parameter int DIV_W = 10,
  parameter int PW    = 8,
  parameter int HW    = 11,
  parameter int VW    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [PW-1:0]    h_sw,
  input  logic [PW-1:0]    h_bp,
  input  logic [HW-1:0]    h_act,
  input  logic [PW-1:0]    h_fp,
  input  logic [PW-1:0]    v_sw,
  input  logic [PW-1:0]    v_bp,
  input  logic [VW-1:0]    v_act,
  input  logic [PW-1:0]    v_fp,
  input  logic             hs_inv,
  input  logic             vs_inv,
  output logic             pix_ce,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [HW-1:0]    col,
  output logic [VW-1:0]    row
);
  localparam int CW  = DIV_W + 1;
  localparam int HCW = ((HW > PW) ? HW : PW) + 2;
  localparam int VCW = ((VW > PW) ? VW : PW) + 2;

  logic           running;
  logic [CW-1:0]  dcnt;
  logic [HCW-1:0] hcnt, h_last, h_start, h_end;
  logic [VCW-1:0] vcnt, v_last, v_start, v_end;
  logic           h_on, v_on;

  wire [CW-1:0] d_last = {clk_div, 1'b1};

  assign h_start = HCW'(h_sw) + HCW'(h_bp) + HCW'(2);
  assign h_end   = h_start + HCW'(h_act);
  assign h_last  = h_end + HCW'(h_fp) + HCW'(1);
  assign v_start = VCW'(v_sw) + VCW'(v_bp) + VCW'(2);
  assign v_end   = v_start + VCW'(v_act);
  assign v_last  = v_end + VCW'(v_fp) + VCW'(1);

  assign pix_ce = running && (dcnt == d_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      dcnt    <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!run) begin
      running <= 1'b0;
      dcnt    <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else begin
      running <= 1'b1;
      if (running) dcnt <= pix_ce ? '0 : dcnt + CW'(1);
      if (pix_ce) begin
        if (hcnt >= h_last) begin
          hcnt <= '0;
          vcnt <= (vcnt >= v_last) ? '0 : vcnt + VCW'(1);
        end else begin
          hcnt <= hcnt + HCW'(1);
        end
      end
    end
  end

  assign h_on  = (hcnt >= h_start) && (hcnt <= h_end);
  assign v_on  = (vcnt >= v_start) && (vcnt <= v_end);
  assign hsync = (running && (hcnt <= HCW'(h_sw))) ^ hs_inv;
  assign vsync = (running && (vcnt <= VCW'(v_sw))) ^ vs_inv;
  assign de    = running && h_on && v_on;
  assign col   = de ? HW'(hcnt - h_start) : '0;
  assign row   = de ? VW'(vcnt - v_start) : '0;
endmodule

// File: rtl/tft_timing_gen_chk.sv
module tft_timing_gen_chk #(
  parameter int HW = 11,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [HW-1:0] h_act,
  input logic          hs_inv,
  input logic          vs_inv,
  input logic          pix_ce,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [HW-1:0] col,
  input logic [VW-1:0] row
);
  p_ce_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hsync == hs_inv) && (vsync == vs_inv) && !de && !pix_ce
             && (col == '0) && (row == '0));

  p_hold_between_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(rst_n) && !pix_ce) |=>
      $stable(de) && $stable(col) && $stable(row) && $stable(hsync ^ hs_inv)
      && $stable(vsync ^ vs_inv));

  p_de_not_in_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == hs_inv) && (vsync == vs_inv));

  p_col_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (col <= h_act));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (col == '0) && (row == '0));
endmodule

bind tft_timing_gen tft_timing_gen_chk #(.HW(HW), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .h_act(h_act),
  .hs_inv(hs_inv), .vs_inv(vs_inv), .pix_ce(pix_ce), .hsync(hsync),
  .vsync(vsync), .de(de), .col(col), .row(row)
);

// File: tb/tft_timing_gen_tb_top.sv
`timescale 1ns/1ps
module tft_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [9:0]  clk_div = '0;
  logic [7:0]  h_sw = '0, h_bp = '0, h_fp = '0, v_sw = '0, v_bp = '0, v_fp = '0;
  logic [10:0] h_act = '0, v_act = '0;
  logic        hs_inv = 1'b0, vs_inv = 1'b0;
  logic        pix_ce, hsync, vsync, de;
  logic [10:0] col, row;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tft_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_div(clk_div),
    .h_sw(h_sw), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
    .v_sw(v_sw), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
    .hs_inv(hs_inv), .vs_inv(vs_inv), .pix_ce(pix_ce), .hsync(hsync),
    .vsync(vsync), .de(de), .col(col), .row(row)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "idle hsync", hsync, hs_inv);
    check(req, "idle vsync", vsync, vs_inv);
    check(req, "idle de", de, 0);
    check(req, "idle pix_ce", pix_ce, 0);
    check(req, "idle col", col, 0);
    check(req, "idle row", row, 0);
  endtask

  // Raises run at a falling edge, then compares every cycle with the model.
  task automatic run_compare(input string req, input int ncyc);
    int p, l, f, hst, vst;
    bit [6:0] err;
    int ea[7], aa[7];
    string nm[7];
    nm = '{"pix_ce", "hsync", "vsync", "de", "col", "row", "period"};
    p   = 2 * (int'(clk_div) + 1);
    l   = int'(h_sw) + int'(h_bp) + int'(h_act) + int'(h_fp) + 4;
    f   = int'(v_sw) + int'(v_bp) + int'(v_act) + int'(v_fp) + 4;
    hst = int'(h_sw) + int'(h_bp) + 2;
    vst = int'(v_sw) + int'(v_bp) + 2;
    err = '0;
    @(negedge clk);
    run = 1'b1;
    for (int n = 1; n <= ncyc; n++) begin
      int pos, h, v, e_ce, e_hs, e_vs, e_de, e_col, e_row;
      int got[7], exp[7];
      @(negedge clk);
      pos   = (n - 1) / p;
      h     = pos % l;
      v     = (pos / l) % f;
      e_ce  = (n % p == 0);
      e_hs  = (h <= int'(h_sw)) ^ hs_inv;
      e_vs  = (v <= int'(v_sw)) ^ vs_inv;
      e_de  = (h >= hst) && (h <= hst + int'(h_act)) && (v >= vst) && (v <= vst + int'(v_act));
      e_col = e_de ? h - hst : 0;
      e_row = e_de ? v - vst : 0;
      got = '{int'(pix_ce), int'(hsync), int'(vsync), int'(de), int'(col), int'(row), 0};
      exp = '{e_ce, e_hs, e_vs, e_de, e_col, e_row, 0};
      for (int k = 0; k < 6; k++)
        if (got[k] != exp[k] && !err[k]) begin
          err[k] = 1'b1; aa[k] = got[k]; ea[k] = exp[k];
        end
    end
    for (int k = 0; k < 6; k++)
      check(req, nm[k], err[k] ? aa[k] : 0, err[k] ? ea[k] : 0);
  endtask

  task automatic stop_gen();
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R10");
  endtask

  task automatic t_basic();
    clk_div = 10'd0; h_sw = 8'd1; h_bp = 8'd2; h_act = 11'd4; h_fp = 8'd0;
    v_sw = 8'd0; v_bp = 8'd1; v_act = 11'd2; v_fp = 8'd1;
    hs_inv = 1'b0; vs_inv = 1'b0;
    run_compare("R1 R2 R3 R4 R5 R6", 2 * 176 + 10);
    stop_gen();
    check_idle("R9");
  endtask

  task automatic t_divided_inverted();
    clk_div = 10'd2; h_sw = 8'd0; h_bp = 8'd1; h_act = 11'd5; h_fp = 8'd2;
    v_sw = 8'd1; v_bp = 8'd0; v_act = 11'd3; v_fp = 8'd0;
    hs_inv = 1'b1; vs_inv = 1'b1;
    run_compare("R1 R7 R8", 12 * 8 * 6 + 30);
    stop_gen();
    check_idle("R7");
    hs_inv = 1'b0;
    #1;
    check("R7", "idle hsync after invert cleared", hsync, 0);
    vs_inv = 1'b0;
  endtask

  task automatic t_minimal_slow();
    clk_div = 10'd1023; h_sw = '0; h_bp = '0; h_act = '0; h_fp = '0;
    v_sw = '0; v_bp = '0; v_act = '0; v_fp = '0;
    run_compare("R11 R1", 16 * 2048 + 2100);
    stop_gen();
    check_idle("R11");
  endtask

  task automatic t_stop_restart();
    clk_div = 10'd0; h_sw = 8'd1; h_bp = 8'd2; h_act = 11'd4; h_fp = 8'd0;
    v_sw = 8'd0; v_bp = 8'd1; v_act = 11'd2; v_fp = 8'd1;
    run_compare("R9", 101);
    stop_gen();
    check_idle("R9");
    repeat (5) @(negedge clk);
    check_idle("R9");
    run_compare("R9 restart", 200);
    stop_gen();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_divided_inverted();
    t_minimal_slow();
    t_stop_restart();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule